// File: doc/BRIEF.md
# Synthesizer Loop-Gain Calibration Controller

This block measures and trims the loop gain of a fractional-N synthesizer during a dedicated calibration interval. It runs on the VCO clock. It takes the reference clock in as a plain signal and resynchronises it, so every count, window boundary and accumulator clear is aligned to the VCO clock. Each measurement has two phases. In the baseline phase the division word passes through unchanged. The VCO cycles inside each reference-defined window are counted, and the window counts are summed into an accumulator to give a baseline total. In the step phase a small constant is added to the division word sent to the delta-sigma modulator, and the same counting and summing gives a second total. The difference between the two totals cancels the large count that the carrier alone produces. What remains is a double integral of the step response, which grows as the loop gets slower.

The controller compares that difference with a programmable target band. It moves a charge-pump current code one step toward the band and repeats the measurement. It stops when the result falls inside the band or when the iteration budget runs out, then raises a completion flag and holds the last result.

Top module: `pll_gain_cal`

## Requirements
- R1: After reset, calDone is 0, cpCode equals CODE_INIT (8 by default), measResult is 0, accSat is 0 and divOut equals divIn.
- R2: divOut equals divIn + STEP during the step phase of every measurement and equals divIn at all other times.
- R3: A window spans winLen reference periods. The VCO cycles in each window are added to the accumulator, and NWIN windows make up one phase, so a steady reference period of P VCO cycles gives a phase total of NWIN*winLen*P.
- R4: measResult is a signed value equal to the step-phase total minus the baseline total. With equal reference periods in both phases it is 0.
- R5: The first SETTLE (2) reference periods after each phase change are not counted, so a period change that happens at the phase change does not disturb either total.
- R6: After each measurement, the code goes up by one if measResult > target + tolerance (saturating at 15) and down by one if measResult < target - tolerance (saturating at 0). Otherwise the code is unchanged.
- R7: calDone rises after a measurement that lands inside the band, or after MAX_ITER measurements, and stays high with cpCode and measResult held until the next accepted start. An accepted start reloads CODE_INIT.
- R8: A start edge that arrives while a calibration is running has no effect on the outcome.
- R9: If an addition would overflow the accumulator, the accumulator clamps to all ones and accSat goes high. accSat stays high until the next accepted start.
- R10: startReq and refClk each pass through a two-flop synchronizer. Only a rising edge of startReq starts a run, so holding startReq high does not restart after calDone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | VCO clock, the only clock of the block |
| rstN | input | 1 | Asynchronous active-low reset |
| refClk | input | 1 | Reference clock, sampled as data |
| startReq | input | 1 | Calibration request; a rising edge starts a run |
| divIn | input | DIV_W | Nominal division word |
| winLen | input | WL_W | Reference periods per window (1 or more) |
| target | input | ACC_W+1 | Signed target for the measurement |
| tolerance | input | ACC_W | Half-width of the acceptance band |
| divOut | output | DIV_W | Division word sent to the modulator |
| cpCode | output | CODE_W | Charge-pump current code |
| calDone | output | 1 | Calibration finished |
| measResult | output | ACC_W+1 | Signed result of the last measurement |
| accSat | output | 1 | Accumulator clamped during this run |

## Verification
The bench builds the block with ACC_W=12, CNT_W=12, NWIN=4, MAX_ITER=8 and STEP=3. A narrow accumulator lets a single long-window run reach the clamp in a few thousand cycles. With eight iterations starting from code 8, the code can climb all the way to its upper limit and then hold there. The bench's reference generator slows its period during the step phase by an amount that shrinks as cpCode rises, so each seeded case exercises a real closed-loop search whose result the bench can predict exactly.

// File: rtl/lgc_pkg.sv
package lgc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_BSET, ST_BMEAS, ST_SSET, ST_SMEAS, ST_EVAL, ST_DONE
  } calState_t;

  typedef struct packed {
    logic clrAll;
    logic clrWin;
    logic saveBase;
    logic addWin;
    logic takeMetric;
  } calStb_t;
endpackage

// File: rtl/lgc_edge_sync.sv
module lgc_edge_sync (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic rise
);
  logic [2:0] stage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage <= '0;
    else       stage <= {stage[1:0], din};
  end

  assign rise = stage[1] & ~stage[2];

  // R10: a detected edge lasts exactly one cycle
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rise |=> !rise);
endmodule

// File: rtl/lgc_ctrl.sv
module lgc_ctrl
  import lgc_pkg::*;
#(
  parameter int DIV_W     = 24,
  parameter int WL_W      = 8,
  parameter int ACC_W     = 40,
  parameter int CODE_W    = 4,
  parameter int CODE_INIT = 8,
  parameter int NWIN      = 4,
  parameter int SETTLE    = 2,
  parameter int MAX_ITER  = 16,
  parameter int STEP      = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    refTick,
  input  logic                    startPulse,
  input  logic [DIV_W-1:0]        divIn,
  input  logic [WL_W-1:0]         winLen,
  input  logic signed [ACC_W:0]   target,
  input  logic [ACC_W-1:0]        tolerance,
  input  logic signed [ACC_W:0]   measNow,
  output calStb_t                 stb,
  output logic [CODE_W-1:0]       cpCode,
  output logic                    calDone,
  output logic [DIV_W-1:0]        divOut
);
  localparam int WIN_W  = $clog2(NWIN + 1);
  localparam int ITER_W = $clog2(MAX_ITER + 1);
  localparam int SET_W  = $clog2(SETTLE + 1);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  calState_t          state;
  logic [SET_W-1:0]   setCnt;
  logic [WL_W-1:0]    refIdx;
  logic [WIN_W-1:0]   winIdx;
  logic [ITER_W-1:0]  iter;

  logic inSettle, inMeas, settleEnd, lastRef, lastWin, idleLike;
  logic signed [ACC_W+1:0] measX, hiLim, loLim;
  logic goUp, goDown;

  assign idleLike  = (state == ST_IDLE) || (state == ST_DONE);
  assign inSettle  = (state == ST_BSET) || (state == ST_SSET);
  assign inMeas    = (state == ST_BMEAS) || (state == ST_SMEAS);
  assign settleEnd = refTick && (setCnt == SET_W'(SETTLE - 1));
  assign lastRef   = refTick && (refIdx == winLen - WL_W'(1));
  assign lastWin   = (winIdx == WIN_W'(NWIN - 1));

  assign measX  = {measNow[ACC_W], measNow};
  assign hiLim  = {target[ACC_W], target} + $signed({2'b00, tolerance});
  assign loLim  = {target[ACC_W], target} - $signed({2'b00, tolerance});
  assign goUp   = measX > hiLim;
  assign goDown = measX < loLim;

  always_comb begin
    stb            = '0;
    stb.clrAll     = startPulse && idleLike;
    stb.clrWin     = settleEnd && inSettle;
    stb.saveBase   = settleEnd && (state == ST_SSET);
    stb.addWin     = lastRef && inMeas;
    stb.takeMetric = (state == ST_EVAL);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cpCode <= CODE_W'(CODE_INIT);
      iter   <= '0;
      setCnt <= '0;
      refIdx <= '0;
      winIdx <= '0;
    end else begin
      unique case (state)
        ST_IDLE, ST_DONE: if (startPulse) begin
          state  <= ST_BSET;
          cpCode <= CODE_W'(CODE_INIT);
          iter   <= '0;
          setCnt <= '0;
        end
        ST_BSET, ST_SSET: if (refTick) begin
          if (settleEnd) begin
            state  <= (state == ST_BSET) ? ST_BMEAS : ST_SMEAS;
            refIdx <= '0;
            winIdx <= '0;
          end else begin
            setCnt <= setCnt + 1'b1;
          end
        end
        ST_BMEAS, ST_SMEAS: if (refTick) begin
          if (lastRef) begin
            refIdx <= '0;
            if (lastWin) begin
              state  <= (state == ST_BMEAS) ? ST_SSET : ST_EVAL;
              setCnt <= '0;
            end else begin
              winIdx <= winIdx + 1'b1;
            end
          end else begin
            refIdx <= refIdx + 1'b1;
          end
        end
        ST_EVAL: begin
          if (goUp && cpCode != CODE_MAX)       cpCode <= cpCode + 1'b1;
          else if (goDown && cpCode != '0)      cpCode <= cpCode - 1'b1;
          iter <= iter + 1'b1;
          if ((!goUp && !goDown) || iter == ITER_W'(MAX_ITER - 1)) begin
            state <= ST_DONE;
          end else begin
            state  <= ST_BSET;
            setCnt <= '0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign calDone = (state == ST_DONE);
  assign divOut  = ((state == ST_SSET) || (state == ST_SMEAS))
                   ? divIn + DIV_W'(STEP) : divIn;

  // R6: the code only moves in the evaluation cycle or on a fresh start
  a_r6_code_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_EVAL && !stb.clrAll) |=> $stable(cpCode));
  // R6: one evaluation moves the code by at most one step
  a_r6_single_step: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_EVAL) |=> (cpCode == $past(cpCode) || cpCode == $past(cpCode) + 1'b1
                            || cpCode == $past(cpCode) - 1'b1));
  // R7: completion holds until a start edge
  a_r7_done_held: assert property (@(posedge clk) disable iff (!rstN)
    (calDone && !startPulse) |=> calDone);
  // R8: a start edge during measurement does not disturb the sequence
  a_r8_busy_start: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BMEAS && startPulse) |=> (state == ST_BMEAS || state == ST_SSET));
endmodule

// File: rtl/lgc_datapath.sv
module lgc_datapath
  import lgc_pkg::*;
#(
  parameter int ACC_W = 40,
  parameter int CNT_W = 24
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  calStb_t               stb,
  output logic signed [ACC_W:0] measNow,
  output logic signed [ACC_W:0] measResult,
  output logic                  accSat
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] vcoCnt;
  logic [ACC_W-1:0] acc, accBase;
  logic [ACC_W:0]   sum;

  assign sum     = {1'b0, acc} + {{(ACC_W + 1 - CNT_W){1'b0}}, vcoCnt};
  assign measNow = $signed({1'b0, acc}) - $signed({1'b0, accBase});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vcoCnt     <= '0;
      acc        <= '0;
      accBase    <= '0;
      measResult <= '0;
      accSat     <= 1'b0;
    end else begin
      if (stb.clrWin || stb.addWin)  vcoCnt <= CNT_W'(1);
      else if (vcoCnt != CNT_MAX)    vcoCnt <= vcoCnt + 1'b1;

      if (stb.saveBase) accBase <= acc;
      else if (stb.clrAll) accBase <= '0;

      if (stb.clrAll || stb.clrWin) begin
        acc <= '0;
      end else if (stb.addWin) begin
        if (sum[ACC_W]) begin
          acc    <= '1;
          accSat <= 1'b1;
        end else begin
          acc <= sum[ACC_W-1:0];
        end
      end

      if (stb.clrAll) accSat <= 1'b0;

      if (stb.clrAll)          measResult <= '0;
      else if (stb.takeMetric) measResult <= measNow;
    end
  end

  // R9: the clamp flag is sticky within a run
  a_r9_sat_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (accSat && !stb.clrAll) |=> accSat);
  // R3: the accumulator never shrinks between clears
  a_r3_acc_grows: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.clrAll && !stb.clrWin) |=> acc >= $past(acc));
  // R4: the published result changes only at evaluation or start
  a_r4_result_held: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.takeMetric && !stb.clrAll) |=> $stable(measResult));
endmodule

// File: rtl/pll_gain_cal.sv
module pll_gain_cal
  import lgc_pkg::*;
#(
  parameter int DIV_W     = 24,
  parameter int WL_W      = 8,
  parameter int ACC_W     = 40,
  parameter int CNT_W     = 24,
  parameter int CODE_W    = 4,
  parameter int CODE_INIT = 8,
  parameter int NWIN      = 4,
  parameter int SETTLE    = 2,
  parameter int MAX_ITER  = 16,
  parameter int STEP      = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  refClk,
  input  logic                  startReq,
  input  logic [DIV_W-1:0]      divIn,
  input  logic [WL_W-1:0]       winLen,
  input  logic signed [ACC_W:0] target,
  input  logic [ACC_W-1:0]      tolerance,
  output logic [DIV_W-1:0]      divOut,
  output logic [CODE_W-1:0]     cpCode,
  output logic                  calDone,
  output logic signed [ACC_W:0] measResult,
  output logic                  accSat
);
  logic refTick, startPulse;
  logic signed [ACC_W:0] measNow;
  calStb_t stb;

  lgc_edge_sync uRefSync   (.clk(clk), .rstN(rstN), .din(refClk),   .rise(refTick));
  lgc_edge_sync uStartSync (.clk(clk), .rstN(rstN), .din(startReq), .rise(startPulse));

  lgc_ctrl #(
    .DIV_W(DIV_W), .WL_W(WL_W), .ACC_W(ACC_W), .CODE_W(CODE_W),
    .CODE_INIT(CODE_INIT), .NWIN(NWIN), .SETTLE(SETTLE),
    .MAX_ITER(MAX_ITER), .STEP(STEP)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .refTick(refTick), .startPulse(startPulse),
    .divIn(divIn), .winLen(winLen), .target(target), .tolerance(tolerance),
    .measNow(measNow), .stb(stb), .cpCode(cpCode), .calDone(calDone),
    .divOut(divOut)
  );

  lgc_datapath #(.ACC_W(ACC_W), .CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .measNow(measNow),
    .measResult(measResult), .accSat(accSat)
  );

  // R2: once finished, the nominal division word is passed through
  a_r2_idle_div: assert property (@(posedge clk) disable iff (!rstN)
    calDone |-> divOut == divIn);
endmodule

// File: tb/pll_gain_cal_test.sv
module pll_gain_cal_test;
  localparam int DIV_W = 16, WL_W = 8, ACC_W = 12, CNT_W = 12;
  localparam int NWIN = 4, MAX_ITER = 8, STEP = 3, INIT = 8;

  logic clk = 0, rstN = 0, refClk = 0, startReq = 0;
  logic [DIV_W-1:0] divIn = 16'd1200;
  logic [WL_W-1:0] winLen = 8'd2;
  logic signed [ACC_W:0] target = '0;
  logic [ACC_W-1:0] tolerance = '0;
  logic [DIV_W-1:0] divOut;
  logic [3:0] cpCode;
  logic calDone, accSat;
  logic signed [ACC_W:0] measResult;

  int checks = 0, fails = 0, cycles = 0;
  int bh = 10, slow = 0, halfP = 10, hcnt = 0;
  int stepErr = 0, sawStep = 0;

  pll_gain_cal #(.DIV_W(DIV_W), .WL_W(WL_W), .ACC_W(ACC_W), .CNT_W(CNT_W),
    .NWIN(NWIN), .MAX_ITER(MAX_ITER), .STEP(STEP), .CODE_INIT(INIT)) uut (
    .clk(clk), .rstN(rstN), .refClk(refClk), .startReq(startReq), .divIn(divIn),
    .winLen(winLen), .target(target), .tolerance(tolerance), .divOut(divOut),
    .cpCode(cpCode), .calDone(calDone), .measResult(measResult), .accSat(accSat));

  always #2.5 clk = ~clk;

  // reference model: the step phase slows the period less as cpCode rises
  always @(posedge clk) begin
    if (!rstN) begin
      refClk <= 0; hcnt <= 0;
    end else begin
      halfP <= (divOut != divIn) ? bh + ((slow > int'(cpCode)) ? slow - int'(cpCode) : 0) : bh;
      if (hcnt >= halfP - 1) begin refClk <= ~refClk; hcnt <= 0; end
      else hcnt <= hcnt + 1;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rstN && divOut != divIn) begin
      sawStep = 1;
      if (divOut != divIn + DIV_W'(STEP)) stepErr++;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void predict(input int slw, input int wl, input int tgt, input int tol,
                                  output int code, output int meas);
    code = INIT; meas = 0;
    for (int it = 0; it < MAX_ITER; it++) begin
      meas = 2 * NWIN * wl * ((slw > code) ? slw - code : 0);
      if (meas > tgt + tol) begin if (code < 15) code++; end
      else if (meas < tgt - tol) begin if (code > 0) code--; end
      else break;
    end
  endfunction

  task automatic pulseStart();
    startReq = 1; repeat (4) @(negedge clk); startReq = 0;
  endtask

  task automatic waitDone(output bit ok);
    int n = 0;
    ok = 1;
    while (!calDone) begin
      @(negedge clk); n++;
      if (n > 40000) begin ok = 0; break; end
    end
  endtask

  // mode: 0 normal, 1 hold start high (R10), 2 poke start while busy (R8)
  task automatic runCal(input int b, input int slw, input int wl, input int tgt,
                        input int tol, input int mode, input string tag);
    int eCode, eMeas;
    bit ok;
    @(negedge clk);
    bh = b; slow = slw; winLen = WL_W'(wl);
    target = (ACC_W+1)'(tgt); tolerance = ACC_W'(tol);
    stepErr = 0; sawStep = 0;
    predict(slw, wl, tgt, tol, eCode, eMeas);
    startReq = 1; repeat (4) @(negedge clk);
    if (mode != 1) startReq = 0;
    repeat (4) @(negedge clk);
    check({tag, " R7 done cleared by start"}, calDone, 0);
    if (mode == 2) begin repeat (300) @(negedge clk); pulseStart(); end
    waitDone(ok);
    if (!ok) check({tag, " watchdog R7"}, 0, 1);
    check({tag, " R6 final code"}, cpCode, eCode);
    check({tag, " R4 R5 R3 result"}, measResult, eMeas);
    check({tag, " R9 no clamp"}, accSat, 0);
    check({tag, " R2 step word seen"}, sawStep, 1);
    check({tag, " R2 step word value"}, stepErr, 0);
    check({tag, " R2 idle word"}, divOut, divIn);
    if (mode == 1) begin
      repeat (200) @(negedge clk);
      check({tag, " R10 level start no restart"}, calDone, 1);
      check({tag, " R7 code held"}, cpCode, eCode);
      startReq = 0;
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 done", calDone, 0);
    check("R1 code", cpCode, INIT);
    check("R1 result", measResult, 0);
    check("R1 sat", accSat, 0);
    check("R1 div", divOut, divIn);
    rstN = 1;
    repeat (20) @(negedge clk);
    check("R10 no start without edge", calDone, 0);

    runCal(10, 0, 2, 0, 0, 0, "equal periods");
    runCal(9, 0, 2, -1, 0, 0, "upper clamp");
    runCal(8, 15, 3, 4000, 0, 0, "downward");
    runCal(11, 12, 2, 40, 8, 1, "held start");
    runCal(7, 14, 3, 100, 20, 2, "busy start");
    for (int k = 0; k < 4; k++) begin
      int b = int'($urandom_range(6, 12));
      int s = int'($urandom_range(0, 15));
      int w = int'($urandom_range(2, 3));
      int t = int'($urandom_range(0, 300));
      int l = int'($urandom_range(0, 40));
      divIn = DIV_W'($urandom_range(100, 60000));
      runCal(b, s, w, t, l, 0, "random");
    end

    // R9: 4 windows of 50*40 cycles exceed the 12-bit accumulator
    begin
      bit ok;
      @(negedge clk);
      bh = 20; slow = 0; winLen = 8'd50; target = '0; tolerance = '0;
      pulseStart();
      repeat (4) @(negedge clk);
      waitDone(ok);
      if (!ok) check("clamp watchdog R9", 0, 1);
      check("R9 clamp flag", accSat, 1);
      check("R9 clamped totals cancel R4", measResult, 0);
    end
    runCal(10, 10, 2, 0, 0, 0, "after clamp");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 190000);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule